// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block holds the digital timing and counting for an integrating converter that works with two slopes. The integrator, its switch network and the comparator that senses the integrator crossing zero lie outside. Once a start pulse arrives, the block runs a fixed series of phases and drives one switch select for each phase:

- an auto-zero interval on the zero select;
- a run-up of exactly 2^N clocks on the input select;
- a run-down on the reference select. The run-down is timed until the comparator shows that the integrator has come back to zero;
- an integrator-zero interval that clears any charge left over before the next conversion.

The count reached during the run-down is the conversion result. It scales with Vin/Vref × 2^N, so one conversion takes 2^N plus the count in clock periods. The comparator output is asynchronous and passes through a synchroniser. The zero crossing is taken from the falling edge of the synchronised level, not from the level. A run-down that reaches full scale without a crossing ends the conversion and sets an overrange flag.

Top module: `dsadc_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `overrange`, all three selects and `result` are 0.
- R2: A `start` pulse seen while idle begins a conversion. `sel_zero` is high for exactly AZ_LEN clocks (auto-zero). After that, `sel_in` is high for exactly 2^N clocks (run-up).
- R3: `sel_ref` rises on the clock edge where `sel_in` falls. Count the rising edges after that one, and let k (k ≥ 1) be the first edge that samples `cmp_in` low after it was high. The result is then k+1 and `overrange` is 0, provided k+1 ≤ 2^N−1. `sel_ref` is high for k+2 clocks.
- R4: The result counts as full scale when no falling edge of the synchronised comparator occurs within 2^N run-down clocks. This covers a comparator that is already low when the run-down begins. The same applies to a falling edge that would give k+1 > 2^N−1. In all these cases `sel_ref` is high for exactly 2^N clocks, `result` becomes all ones and `overrange` becomes 1.
- R5: `done` is a one-clock pulse and occurs once per conversion, in the cycle in which `result` and `overrange` first show their new values. Both values hold until the next `done`.
- R6: After the run-down, `sel_zero` is high again (integrator-zero phase). It stays high until an edge samples the synchronised comparator low, or for `zero_max`+1 clocks, whichever comes first. After that the block is idle and `busy` is 0.
- R7: A `start` pulse while `busy` is high is ignored. The phase lengths and the result of the conversion in progress are unchanged.
- R8: At most one of `sel_in`, `sel_ref` and `sel_zero` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (taken only while idle) |
| cmp_in | input | 1 | Asynchronous comparator, 1 while the integrator is away from zero |
| zero_max | input | ZW | Integrator-zero limit; the phase lasts at most zero_max+1 clocks |
| sel_in | output | 1 | Connect the unknown input to the integrator |
| sel_ref | output | 1 | Connect the opposite-polarity reference |
| sel_zero | output | 1 | Short or zero the integrator (auto-zero and integrator-zero) |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-clock pulse when a new result is latched |
| overrange | output | 1 | The last conversion reached full scale without a crossing |
| result | output | N | Run-down count of the last conversion |

## Verification
The bench builds the block with N = 6, AZ_LEN = 3 and ZW = 4, so the run-up is 64 clocks and full scale is 63. At these values every run-down length can be reached by random stimulus, including the last count before overrange and the counts past it. Each conversion stays short enough for dozens of random cases to run alongside the directed ones. The 4-bit `zero_max` allows an integrator-zero limit of a single clock as well as one that ends on its count limit instead of on the comparator.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_AZERO = 3'd1,
    PH_RUNUP = 3'd2,
    PH_RUNDN = 3'd3,
    PH_IZERO = 3'd4
  } phase_t;

  // Run-up and full-scale run-down length in clocks.
  function automatic int unsigned span_clocks(input int unsigned n);
    return 32'd1 << n;
  endfunction

  // Largest count held by the result register.
  function automatic int unsigned top_count(input int unsigned n);
    return span_clocks(n) - 32'd1;
  endfunction

  // Counter width wide enough for every phase limit.
  function automatic int unsigned count_width(input int unsigned n, input int unsigned zw);
    return ((n > zw) ? n : zw) + 2;
  endfunction

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              level_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign fall  = level_q & ~level;

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int N      = 8,
  parameter int AZ_LEN = 4,
  parameter int ZW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmp_level,
  input  logic          cmp_fall,
  input  logic [ZW-1:0] zero_max,
  output phase_t        phase,
  output logic [N-1:0]  rd_count,
  output logic          cap_evt,
  output logic          cap_hit
);

  localparam int CW = count_width(N, ZW);
  localparam logic [CW-1:0] AZ_LAST  = CW'(AZ_LEN - 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(top_count(N));

  logic [CW-1:0] cnt;
  logic [CW-1:0] zlim;
  logic          rd_full;
  logic          iz_exit;

  assign zlim     = {{(CW-ZW){1'b0}}, zero_max};
  assign rd_full  = (cnt == RUN_LAST);
  assign iz_exit  = ~cmp_level | (cnt >= zlim);
  assign cap_evt  = (phase == PH_RUNDN) & (cmp_fall | rd_full);
  assign cap_hit  = cmp_fall;
  assign rd_count = cnt[N-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (start) phase <= PH_AZERO;
        end
        PH_AZERO: begin
          if (cnt == AZ_LAST) begin
            phase <= PH_RUNUP;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_RUNUP: begin
          if (cnt == RUN_LAST) begin
            phase <= PH_RUNDN;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_RUNDN: begin
          if (cap_evt) begin
            phase <= PH_IZERO;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_IZERO: begin
          if (iz_exit) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  // R2: run-up leaves exactly at its last count
  assert_runup_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUNUP && cnt == RUN_LAST) |=> (phase == PH_RUNDN));
  assert_runup_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUNUP && cnt != RUN_LAST) |=> (phase == PH_RUNUP));
  // R3: a comparator fall during run-down ends it
  assert_fall_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUNDN && cmp_fall) |=> (phase == PH_IZERO));
  // R6: integrator-zero ends once the comparator reads zero
  assert_izero_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IZERO && !cmp_level) |=> (phase == PH_IDLE));
  // R7: start during run-up or run-down does not restart
  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_RUNUP || phase == PH_RUNDN) && start) |=> (phase != PH_AZERO));

endmodule

// File: rtl/dsadc_result.sv
module dsadc_result #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_evt,
  input  logic         cap_hit,
  input  logic [N-1:0] rd_count,
  output logic         done,
  output logic         overrange,
  output logic [N-1:0] result
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      overrange <= 1'b0;
      result    <= '0;
    end else begin
      done <= cap_evt;
      if (cap_evt) begin
        overrange <= ~cap_hit;
        result    <= cap_hit ? rd_count : {N{1'b1}};
      end
    end
  end

  // R5: done is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: result holds between updates
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(overrange)));
  // R4: overrange comes with a full-scale result
  assert_ovr_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overrange) |-> (result == {N{1'b1}}));

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int N      = 8,
  parameter int AZ_LEN = 4,
  parameter int ZW     = 8,
  parameter int SYNC   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmp_in,
  input  logic [ZW-1:0] zero_max,
  output logic          sel_in,
  output logic          sel_ref,
  output logic          sel_zero,
  output logic          busy,
  output logic          done,
  output logic          overrange,
  output logic [N-1:0]  result
);

  phase_t       phase;
  logic         cmp_level;
  logic         cmp_fall;
  logic [N-1:0] rd_count;
  logic         cap_evt;
  logic         cap_hit;

  dsadc_sync #(.STAGES(SYNC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cmp_in),
    .level    (cmp_level),
    .fall     (cmp_fall)
  );

  dsadc_seq #(.N(N), .AZ_LEN(AZ_LEN), .ZW(ZW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmp_level (cmp_level),
    .cmp_fall  (cmp_fall),
    .zero_max  (zero_max),
    .phase     (phase),
    .rd_count  (rd_count),
    .cap_evt   (cap_evt),
    .cap_hit   (cap_hit)
  );

  dsadc_result #(.N(N)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_evt   (cap_evt),
    .cap_hit   (cap_hit),
    .rd_count  (rd_count),
    .done      (done),
    .overrange (overrange),
    .result    (result)
  );

  assign sel_in   = (phase == PH_RUNUP);
  assign sel_ref  = (phase == PH_RUNDN);
  assign sel_zero = (phase == PH_AZERO) || (phase == PH_IZERO);
  assign busy     = (phase != PH_IDLE);

  // R8: switch selects never overlap
  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_in, sel_ref, sel_zero}));
  // R5: done only appears while the conversion is still busy
  assert_done_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

endmodule

// File: tb/tb_dsadc_ctrl.sv
module tb_dsadc_ctrl;

  localparam int N      = 6;
  localparam int AZ_LEN = 3;
  localparam int ZW     = 4;
  localparam int SPAN   = 1 << N;
  localparam int FULL   = SPAN - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          cmp_in = 1'b0;
  logic [ZW-1:0] zero_max = '0;
  logic          sel_in, sel_ref, sel_zero, busy, done, overrange;
  logic [N-1:0]  result;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dsadc_ctrl #(.N(N), .AZ_LEN(AZ_LEN), .ZW(ZW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
    .zero_max(zero_max), .sel_in(sel_in), .sel_ref(sel_ref),
    .sel_zero(sel_zero), .busy(busy), .done(done),
    .overrange(overrange), .result(result)
  );

  function automatic bit exp_ovr(input int k, input bit hi);
    return !hi || (k + 1 > FULL);
  endfunction

  function automatic int exp_res(input int k, input bit hi);
    return exp_ovr(k, hi) ? FULL : k + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // k: rising edge that first samples the comparator low; hi: comparator high at start
  task automatic run_conv(input int k, input bit hi, input int zm, input bit poke);
    int az = 0, inn = 0, rf = 0, iz = 0, dn = 0, oh = 0;
    int got_r = -1, got_o = -1;
    bit eo;
    eo = exp_ovr(k, hi);
    zero_max = ZW'(zm);
    cmp_in = hi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) begin
      if (sel_zero && rf == 0) az++;
      if (sel_zero && rf > 0) iz++;
      if (sel_in) inn++;
      if (sel_ref) rf++;
      if (int'(sel_in) + int'(sel_ref) + int'(sel_zero) > 1) oh++;
      if (done) begin
        dn++;
        got_r = int'(result);
        got_o = int'(overrange);
      end
      start = poke && sel_in && (inn == 5);
      if (hi && !eo && sel_ref && rf == k) cmp_in = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(az == AZ_LEN, "R2", "auto-zero clocks", az, AZ_LEN);
    chk(inn == SPAN, poke ? "R7" : "R2", "run-up clocks", inn, SPAN);
    chk(rf == (eo ? SPAN : k + 2), eo ? "R4" : "R3", "run-down clocks", rf, eo ? SPAN : k + 2);
    chk(got_r == exp_res(k, hi), eo ? "R4" : "R3", "result", got_r, exp_res(k, hi));
    chk(got_o == int'(eo), eo ? "R4" : "R3", "overrange", got_o, int'(eo));
    chk(dn == 1, "R5", "done pulses", dn, 1);
    chk(iz == ((eo && hi) ? zm + 1 : 1), "R6", "integrator-zero clocks", iz, (eo && hi) ? zm + 1 : 1);
    chk(oh == 0, "R8", "overlapping selects", oh, 0);
    cmp_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(int'(result) == got_r, "R5", "result held", int'(result), got_r);
    chk(done == 1'b0 && busy == 1'b0, "R6", "idle after conversion", int'({done, busy}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy, done, overrange, sel_in, sel_ref, sel_zero} == 6'b0, "R1",
        "control outputs in reset", int'({busy, done, overrange, sel_in, sel_ref, sel_zero}), 0);
    chk(result == '0, "R1", "result in reset", int'(result), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R1", "idle after reset", int'(busy), 0);

    // directed corners
    run_conv(1, 1'b1, 3, 1'b0);          // R3 smallest run-down
    run_conv(FULL - 1, 1'b1, 2, 1'b0);   // R3 last count before overrange
    run_conv(FULL, 1'b1, 5, 1'b0);       // R4 one past full scale
    run_conv(SPAN + 20, 1'b1, 0, 1'b0);  // R4 no crossing, zero_max 0
    run_conv(10, 1'b0, 7, 1'b0);         // R4 comparator already low: no edge
    run_conv(20, 1'b1, 15, 1'b1);        // R7 start while busy
    run_conv(SPAN + 5, 1'b1, 15, 1'b1);  // R6 integrator-zero hits its limit

    // random conversions
    for (int i = 0; i < 40; i++) begin
      run_conv(int'($urandom_range(1, SPAN + 3)), 1'b1,
               int'($urandom_range(0, 15)), bit'($urandom_range(0, 1)));
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule